// File: doc/BRIEF.md
# PROM Programming Pulse Sequencer

This block steps a 256-word by 8-bit programmable ROM through its programming cycle. Software or a loader fills an image buffer beforehand. A single start request then makes the sequencer read each word from the buffer through a word-fetch port, in ascending address order. For each word it drives the address and the data pins, waits out an address setup interval, fires one program pulse, and then keeps the pulse low for a recovery interval. That interval keeps the pulse duty cycle at or below 2%.

The cells of an erased device all read HIGH, and a pulse can only turn selected cells LOW. All eight bits of a word are written by the same pulse. The device takes its programming data in negative logic, so the sequencer drives the bitwise inverse of each image word. An image bit of 0 asks for a LOW cell and is driven as a high data level, which is the level that programs that cell. Chip select stays in its disabled (high) state for the whole time. The high-voltage pulse generation and level shifting sit outside this block, driven from its logic-level pulse enable.

Timing comes from parameters given in clock cycles: `SETUP_CYC` sets the setup time and `PULSE_CYC` sets the pulse width. The recovery time is derived from the pulse width as `(DUTY_DIV-1)*PULSE_CYC` with `DUTY_DIV = 50`. Both `SETUP_CYC` and `PULSE_CYC` must be at least 1.

Top module: `prom_pulse_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `progPulse` are 0, `romAddr` is 0, `romData` is 0 (the level that programs nothing), and the block waits in its idle state.
- R2: A `startReq` seen while idle raises `busy` on the next cycle. Words are then programmed in strictly ascending order from address 0 to 255, with exactly one pulse per word, and `fetchAddr` always equals `romAddr`.
- R3: Before each rising edge of `progPulse`, `romAddr` and `romData` have been unchanged for at least `SETUP_CYC` cycles.
- R4: Each pulse lasts exactly `PULSE_CYC` cycles. After it, `progPulse` stays low for at least `49*PULSE_CYC` cycles before the address advances or the run ends, so the pulse period is at least 50 pulse widths.
- R5: `romAddr` and `romData` do not change while `progPulse` is high, nor during the recovery time that follows it.
- R6: For every address, `romData` during that word's pulse is the bitwise inverse of the image word `fetchData` returned for that address. Bit i of `romData` corresponds to bit i of the image word.
- R7: `chipSelN` is 1 (disabled) at all times.
- R8: After the recovery time of address 255, `done` is 1 for exactly one cycle. `busy` is 0 in that cycle, and the block then returns to idle, where a new `startReq` is accepted.
- R9: A `startReq` that arrives while `busy` is 1 is ignored. The address sequence continues without restarting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to begin a programming run |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle strobe at the end of a run |
| fetchAddr | output | 8 | Address of the word requested from the image buffer |
| fetchData | input | 8 | Image word for `fetchAddr`, valid in the same cycle |
| romAddr | output | 8 | Address driven to the device, positive logic |
| romData | output | 8 | Data driven to the device, inverted image word |
| chipSelN | output | 1 | Device chip select, active low, held high |
| progPulse | output | 1 | Program pulse enable |

## Verification
The bench builds the block with `SETUP_CYC = 3` and `PULSE_CYC = 2`. This makes one word take 105 cycles, so a full pass over all 256 addresses fits easily in a run. The short windows still leave room for the setup, pulse-width and 49-width recovery checks to catch off-by-one errors. A full pass lets the bench compare every word that was captured against the inverted image, and reach the end-of-run strobe after address 255. It also exercises a start request that arrives mid-run and a reset that lands during a pulse.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_PULSE,
    ST_RECOVER,
    ST_NEXT,
    ST_DONE
  } seqState_t;

  // Strobes from the control FSM to the address/data path
  typedef struct packed {
    logic clrAddr;
    logic loadWord;
    logic incAddr;
  } dpStrobe_t;

endpackage

// File: rtl/prom_seq_ctrl.sv
module prom_seq_ctrl
  import prom_seq_pkg::*;
#(
  parameter int SETUP_CYC = 125,
  parameter int PULSE_CYC = 12500,
  parameter int DUTY_DIV  = 50
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  input  logic      lastWord,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      progPulse
);

  localparam int OFF_CYC = (DUTY_DIV - 1) * PULSE_CYC;
  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CYC = (MAX_A > OFF_CYC) ? MAX_A : OFF_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  localparam logic [TMR_W-1:0] SETUP_LAST = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] PULSE_LAST = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] OFF_LAST   = TMR_W'(OFF_CYC - 1);

  seqState_t        state, nxtState;
  logic [TMR_W-1:0] tmr;
  logic             tmrLast;

  always_comb begin
    case (state)
      ST_SETUP:   tmrLast = (tmr == SETUP_LAST);
      ST_PULSE:   tmrLast = (tmr == PULSE_LAST);
      ST_RECOVER: tmrLast = (tmr == OFF_LAST);
      default:    tmrLast = 1'b0;
    endcase
  end

  always_comb begin
    nxtState = state;
    case (state)
      ST_IDLE:    if (startReq) nxtState = ST_LOAD;
      ST_LOAD:    nxtState = ST_SETUP;
      ST_SETUP:   if (tmrLast) nxtState = ST_PULSE;
      ST_PULSE:   if (tmrLast) nxtState = ST_RECOVER;
      ST_RECOVER: if (tmrLast) nxtState = ST_NEXT;
      ST_NEXT:    nxtState = lastWord ? ST_DONE : ST_LOAD;
      ST_DONE:    nxtState = ST_IDLE;
      default:    nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
    end else begin
      state <= nxtState;
      tmr   <= (nxtState != state) ? '0 : tmr + 1'b1;
    end
  end

  // Start is only acted on in idle (R9)
  assign strobe.clrAddr  = (state == ST_IDLE) && startReq;
  assign strobe.loadWord = (state == ST_LOAD);
  assign strobe.incAddr  = (state == ST_NEXT) && !lastWord;

  assign busy      = (state != ST_IDLE) && (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign progPulse = (state == ST_PULSE);

  // R4: a pulse is always preceded by the setup interval
  a_r4_pulse_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(progPulse) |-> $past(state) == ST_SETUP);

  // R4: recovery is entered only from the pulse
  a_r4_recover_after_pulse: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOVER && $past(state) != ST_RECOVER) |-> $past(state) == ST_PULSE);

  // R8: done is a single-cycle strobe
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/prom_seq_dpath.sv
module prom_seq_dpath
  import prom_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] fetchData,
  output logic [ADDR_W-1:0] addrCnt,
  output logic [DATA_W-1:0] dataReg,
  output logic              lastWord
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addrCnt <= '0;
    end else if (strobe.clrAddr) begin
      addrCnt <= '0;
    end else if (strobe.incAddr) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  // Negative-logic data: a 0 in the image drives the programming level (R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
    end else if (strobe.loadWord) begin
      dataReg <= ~fetchData;
    end
  end

  assign lastWord = (addrCnt == LAST_ADDR);

  // R6: the latched word is the inverse of the fetched image word
  a_r6_data_inverted: assert property (@(posedge clk) disable iff (rst)
    strobe.loadWord |=> dataReg == ~$past(fetchData));

  // R2: address moves only by clear or single increment
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (!strobe.clrAddr && !strobe.incAddr) |=> $stable(addrCnt));

endmodule

// File: rtl/prom_pulse_seq.sv
module prom_pulse_seq
  import prom_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 125,
  parameter int PULSE_CYC = 12500,
  parameter int DUTY_DIV  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] fetchData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romData,
  output logic              chipSelN,
  output logic              progPulse
);

  dpStrobe_t strobe;
  logic      lastWord;
  logic [ADDR_W-1:0] addrCnt;

  prom_seq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .DUTY_DIV  (DUTY_DIV)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .lastWord  (lastWord),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .progPulse (progPulse)
  );

  prom_seq_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .fetchData (fetchData),
    .addrCnt   (addrCnt),
    .dataReg   (romData),
    .lastWord  (lastWord)
  );

  assign fetchAddr = addrCnt;
  assign romAddr   = addrCnt;
  assign chipSelN  = 1'b1;  // R7: device deselected throughout

  // R3: address and data settled in the cycle before the pulse rises
  a_r3_setup_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(progPulse) |-> $stable(romAddr) && $stable(romData));

  // R5: nothing moves under an active pulse or in the cycle after it
  a_r5_hold_pulse: assert property (@(posedge clk) disable iff (rst)
    progPulse |=> $stable(romAddr) && $stable(romData));

  // R8: done and busy never overlap
  a_r8_busy_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/test_prom_pulse_seq.sv
module test_prom_pulse_seq;

  localparam int SETUP = 3;
  localparam int PW    = 2;
  localparam int OFFMIN = 49 * PW;
  localparam int NCHK  = 10;
  localparam logic [7:0] CHK_ADDR [NCHK] = '{8'd0, 8'd1, 8'd2, 8'd85, 8'd127,
                                             8'd128, 8'd170, 8'd200, 8'd254, 8'd255};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic busy, done, chipSelN, progPulse;
  logic [7:0] fetchAddr, fetchData, romAddr, romData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] img(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  assign fetchData = img(fetchAddr);

  prom_pulse_seq #(
    .SETUP_CYC (SETUP),
    .PULSE_CYC (PW)
  ) i_prom_pulse_seq (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .busy      (busy),
    .done      (done),
    .fetchAddr (fetchAddr),
    .fetchData (fetchData),
    .romAddr   (romAddr),
    .romData   (romData),
    .chipSelN  (chipSelN),
    .progPulse (progPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor of pulse timing and captured words
  bit         monOn = 1'b0;
  logic [7:0] capData [256];
  int         capCount = 0;
  int         nextAddr = 0;
  logic       prevPulse = 1'b0;
  logic [7:0] prevAddr = '0, prevData = '0;
  int         stableCnt = 0, pwCnt = 0, offCnt = 0;
  bit         inOff = 1'b0;
  int         csBad = 0;

  always @(negedge clk) begin
    if (!rst && chipSelN !== 1'b1) csBad++;
    if (monOn) begin
      automatic bit changed = (romAddr != prevAddr) || (romData != prevData);
      if (changed && progPulse)
        check(1'b0, "R5 change during pulse", romAddr, prevAddr);
      if (inOff && (changed || done)) begin
        check(offCnt >= OFFMIN, "R4 off time", offCnt, OFFMIN);
        inOff = 1'b0;
      end else if (inOff && !progPulse) begin
        offCnt++;
      end
      stableCnt = changed ? 0 : stableCnt + 1;
      if (progPulse && !prevPulse) begin
        check(stableCnt >= SETUP, "R3 setup", stableCnt, SETUP);
        check(romAddr == nextAddr && fetchAddr == romAddr, "R2 order", romAddr, nextAddr);
        capData[romAddr] = romData;
        capCount++;
        nextAddr++;
        pwCnt = 1;
      end else if (progPulse) begin
        pwCnt++;
      end
      if (!progPulse && prevPulse) begin
        check(pwCnt == PW, "R4 pulse width", pwCnt, PW);
        inOff = 1'b1;
        offCnt = 1;
      end
    end
    prevPulse = progPulse;
    prevAddr  = romAddr;
    prevData  = romData;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && progPulse == 0, "R1 idle flags", {busy, done, progPulse}, 0);
    check(romAddr == 0 && romData == 0, "R1 outputs", romData, 0);
    check(chipSelN == 1, "R7 chip select", chipSelN, 1);

    // Run 1
    monOn = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1, "R2 busy after start", busy, 1);

    // R9: start while busy
    while (romAddr != 8'd3) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (200) @(negedge clk);
    check(romAddr >= 8'd3 && busy, "R9 start ignored", romAddr, 3);

    while (!done) @(negedge clk);
    check(busy == 0, "R8 busy low at done", busy, 0);
    check(romAddr == 8'd255, "R8 last address", romAddr, 255);
    @(negedge clk);
    check(done == 0 && busy == 0, "R8 done one cycle", done, 0);
    check(capCount == 256, "R2 word count", capCount, 256);

    // Table of sampled addresses versus inverted image (R6)
    for (int i = 0; i < NCHK; i++) begin
      check(capData[CHK_ADDR[i]] == ~img(CHK_ADDR[i]), "R6 inverted data",
            capData[CHK_ADDR[i]], ~img(CHK_ADDR[i]));
    end
    begin
      automatic int bad = 0;
      for (int a = 0; a < 256; a++)
        if (capData[a] != ~img(8'(a))) bad++;
      check(bad == 0, "R6 all words", bad, 0);
    end
    check(csBad == 0, "R7 chip select held", csBad, 0);

    // Run 2: restart from idle, then reset during a pulse (R8, R1)
    monOn = 1'b0;
    repeat (2) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1 && romAddr == 0, "R8 restart accepted", romAddr, 0);
    while (!progPulse) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(progPulse == 0 && busy == 0 && done == 0, "R1 reset in pulse", progPulse, 0);
    check(romAddr == 0 && romData == 0, "R1 reset outputs", romData, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 0 && progPulse == 0, "R1 stays idle", busy, 0);
    finish_run();
  end

endmodule